// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt requests from a parameterised set of sources (32 by default) and presents one of them at a time to a processor as a source number, its priority level and a request line. Each source can be configured to trigger on a low or a high level, or on a falling or a rising edge. Each source also has an enable bit and a priority level from 0 to 7. Edge events are captured in a per-source pending bit. Level requests follow their input directly.

The winner is the enabled, requesting source with the numerically lowest level. When several sources share that level, the lowest source number wins. When the processor acknowledges the presented source, the controller pushes that source's level onto an in-service stack. From then on, only requests at a strictly more urgent level reach the processor, so handlers can nest. An end-of-service strobe pops the stack and restores the previous threshold. Sources are configured one at a time through a write port, and a second write port clears a latched edge.

Top module: `pic_vic`

## Requirements
- R1: After reset, `irq_o` is 0 and `irq_id_o` and `irq_lvl_o` are 0. Every source is disabled and set to high-level trigger at level 7. Whenever `irq_o` is 0, `irq_id_o` and `irq_lvl_o` read 0.
- R2: The trigger encoding on `cfg_trig_i` is 2'b00 low level, 2'b01 high level, 2'b10 falling edge and 2'b11 rising edge. A level source requests only while its input sits at the active level. An edge source ignores the opposite edge.
- R3: An active edge sets the source's pending bit, which stays set after the input returns. The pending bit is cleared by a clear write naming the source, or by an acknowledge while that source is presented.
- R4: A source whose enable bit is 0 never drives `irq_o`. Its edge pending bit still latches, and it requests as soon as the source is enabled.
- R5: Among enabled requesting sources, the lowest level number wins.
- R6: Among requesting sources at the winning level, the lowest source number wins.
- R7: `ack_i` while `irq_o` is 1 pushes the presented level. Afterwards only levels strictly below the top of the stack are presented, so equal and less urgent levels are held off.
- R8: `eoi_i` pops the stack and restores the previous threshold. When the stack is empty, `eoi_i` has no effect. `ack_i` while `irq_o` is 0 pushes nothing.
- R9: A level input change reaches `irq_o` one rising clock edge after it is applied. A latched edge reaches `irq_o` after two rising clock edges.
- R10: Nesting reaches a depth equal to the number of levels (8 by default). Unwinding it with end-of-service strobes returns to an empty stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | N_SRC | Raw interrupt inputs |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_src_i | input | ID_W | Source being configured |
| cfg_trig_i | input | 2 | Trigger type (see R2) |
| cfg_lvl_i | input | LVL_W | Priority level, 0 most urgent |
| cfg_en_i | input | 1 | Source enable |
| clr_we_i | input | 1 | Pending-clear strobe |
| clr_src_i | input | ID_W | Source whose pending edge is cleared |
| ack_i | input | 1 | Processor takes the presented source |
| eoi_i | input | 1 | Processor finished the innermost handler |
| irq_o | output | 1 | Request to the processor |
| irq_id_o | output | ID_W | Presented source number |
| irq_lvl_o | output | LVL_W | Presented source level |

## Verification
The bench builds the block with its default parameters: 32 sources and 3 level bits, which gives eight levels. With these values, ties can be set up between sources far apart in index, and every trigger type runs on live sources. Above all, the nesting stack can be filled to all eight entries by raising sources from level 7 up to level 0 and acknowledging each one, then unwound completely.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'b00,
    TRIG_LVL_HI    = 2'b01,
    TRIG_EDGE_FALL = 2'b10,
    TRIG_EDGE_RISE = 2'b11
  } trig_e;
endpackage

// File: rtl/pic_rst_sync.sv
module pic_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pic_src_cond.sv
// Per-source input conditioning: samples the raw line, finds edges,
// keeps edge pending bits and reports a raw request per source.
module pic_src_cond #(
  parameter int N_SRC = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_SRC-1:0]     src_i,
  input  pic_pkg::trig_e       trig_i [N_SRC],
  input  logic [N_SRC-1:0]     clr_i,
  output logic [N_SRC-1:0]     req_o
);
  import pic_pkg::*;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic s_q, s_prev_q, pend_q;
    logic edge_hit, pend_d;

    always_comb begin
      edge_hit = 1'b0;
      unique case (trig_i[g])
        TRIG_EDGE_RISE: edge_hit = s_q & ~s_prev_q;
        TRIG_EDGE_FALL: edge_hit = ~s_q & s_prev_q;
        default:        edge_hit = 1'b0;
      endcase
      if (trig_i[g] == TRIG_EDGE_RISE || trig_i[g] == TRIG_EDGE_FALL)
        pend_d = (pend_q & ~clr_i[g]) | edge_hit;
      else
        pend_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_q      <= 1'b0;
        s_prev_q <= 1'b0;
        pend_q   <= 1'b0;
      end else begin
        s_q      <= src_i[g];
        s_prev_q <= s_q;
        pend_q   <= pend_d;
      end
    end

    always_comb begin
      unique case (trig_i[g])
        TRIG_LVL_LO: req_o[g] = ~s_q;
        TRIG_LVL_HI: req_o[g] = s_q;
        default:     req_o[g] = pend_q;
      endcase
    end
  end
endmodule

// File: rtl/pic_prio_sel.sv
// Two-stage selection: most urgent occupied level, then lowest index in it.
module pic_prio_sel #(
  parameter int N_SRC = 32,
  parameter int LVL_W = 3,
  localparam int N_LVL = 1 << LVL_W,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [LVL_W-1:0] lvl_i [N_SRC],
  input  logic [LVL_W:0]   thr_i,
  output logic             hit_o,
  output logic [ID_W-1:0]  id_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [N_SRC-1:0] at_lvl [N_LVL];
  logic [N_LVL-1:0] lvl_any;
  logic [N_SRC-1:0] sel_vec;
  logic [LVL_W-1:0] best_lvl;
  logic [ID_W-1:0]  best_id;
  logic             found;

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    always_comb begin
      for (int i = 0; i < N_SRC; i++)
        at_lvl[l][i] = req_i[i] && (lvl_i[i] == LVL_W'(l));
    end
    assign lvl_any[l] = |at_lvl[l];
  end

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    for (int l = N_LVL - 1; l >= 0; l--) begin
      if (lvl_any[l]) begin
        found    = 1'b1;
        best_lvl = LVL_W'(l);
      end
    end
    sel_vec = at_lvl[best_lvl];
    best_id = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (sel_vec[i]) best_id = ID_W'(i);
    end
    hit_o = found && ({1'b0, best_lvl} < thr_i);
    id_o  = hit_o ? best_id  : '0;
    lvl_o = hit_o ? best_lvl : '0;
  end
endmodule

// File: rtl/pic_lvl_stack.sv
// Stack of in-service levels; the top entry sets the preemption threshold.
module pic_lvl_stack #(
  parameter int LVL_W = 3,
  localparam int N_LVL = 1 << LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [LVL_W:0]   thr_o,
  output logic [LVL_W:0]   depth_o
);
  logic [LVL_W-1:0] ent_q [N_LVL];
  logic [LVL_W-1:0] ent_d [N_LVL];
  logic [LVL_W:0]   depth_q, depth_d;
  logic [LVL_W-1:0] top_idx;
  logic             empty, full;

  assign empty   = (depth_q == '0);
  assign full    = (depth_q == (LVL_W+1)'(N_LVL));
  assign top_idx = LVL_W'(depth_q - 1'b1);

  always_comb begin
    ent_d   = ent_q;
    depth_d = depth_q;
    if (push_i && pop_i && !empty) begin
      ent_d[top_idx] = push_lvl_i;
    end else if (push_i && !full) begin
      ent_d[depth_q[LVL_W-1:0]] = push_lvl_i;
      depth_d = depth_q + 1'b1;
    end else if (pop_i && !empty) begin
      depth_d = depth_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < N_LVL; i++) ent_q[i] <= '0;
    end else begin
      depth_q <= depth_d;
      if (push_i) ent_q <= ent_d;
    end
  end

  assign thr_o   = empty ? (LVL_W+1)'(N_LVL) : {1'b0, ent_q[top_idx]};
  assign depth_o = depth_q;
endmodule

// File: rtl/pic_vic.sv
module pic_vic #(
  parameter int N_SRC = 32,
  parameter int LVL_W = 3,
  localparam int ID_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             cfg_we_i,
  input  logic [ID_W-1:0]  cfg_src_i,
  input  logic [1:0]       cfg_trig_i,
  input  logic [LVL_W-1:0] cfg_lvl_i,
  input  logic             cfg_en_i,
  input  logic             clr_we_i,
  input  logic [ID_W-1:0]  clr_src_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [ID_W-1:0]  irq_id_o,
  output logic [LVL_W-1:0] irq_lvl_o
);
  import pic_pkg::*;

  logic             rst_n_sync;
  trig_e            trig_q [N_SRC];
  trig_e            trig_d [N_SRC];
  logic [LVL_W-1:0] lvl_q  [N_SRC];
  logic [LVL_W-1:0] lvl_d  [N_SRC];
  logic [N_SRC-1:0] en_q, en_d;
  logic [N_SRC-1:0] clr_vec, raw_req, req;
  logic [LVL_W:0]   thr, depth;
  logic             ack_take;

  pic_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  always_comb begin
    trig_d = trig_q;
    lvl_d  = lvl_q;
    en_d   = en_q;
    if (cfg_we_i) begin
      trig_d[cfg_src_i] = trig_e'(cfg_trig_i);
      lvl_d[cfg_src_i]  = cfg_lvl_i;
      en_d[cfg_src_i]   = cfg_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      en_q <= '0;
      for (int i = 0; i < N_SRC; i++) begin
        trig_q[i] <= TRIG_LVL_HI;
        lvl_q[i]  <= '1;
      end
    end else if (cfg_we_i) begin
      trig_q <= trig_d;
      lvl_q  <= lvl_d;
      en_q   <= en_d;
    end
  end

  assign ack_take = ack_i & irq_o;

  always_comb begin
    clr_vec = '0;
    if (clr_we_i) clr_vec[clr_src_i] = 1'b1;
    if (ack_take) clr_vec[irq_id_o]  = 1'b1;
  end

  pic_src_cond #(.N_SRC(N_SRC)) u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .src_i  (src_i),
    .trig_i (trig_q),
    .clr_i  (clr_vec),
    .req_o  (raw_req)
  );

  assign req = raw_req & en_q;

  pic_prio_sel #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_sel (
    .req_i (req),
    .lvl_i (lvl_q),
    .thr_i (thr),
    .hit_o (irq_o),
    .id_o  (irq_id_o),
    .lvl_o (irq_lvl_o)
  );

  pic_lvl_stack #(.LVL_W(LVL_W)) u_stk (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .push_i     (ack_take),
    .push_lvl_i (irq_lvl_o),
    .pop_i      (eoi_i),
    .thr_o      (thr),
    .depth_o    (depth)
  );
endmodule

// File: rtl/pic_vic_chk.sv
module pic_vic_chk #(
  parameter int N_SRC = 32,
  parameter int LVL_W = 3,
  localparam int N_LVL = 1 << LVL_W,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             irq,
  input logic [ID_W-1:0]  irq_id,
  input logic [LVL_W-1:0] irq_lvl,
  input logic             ack,
  input logic             eoi,
  input logic [LVL_W:0]   thr,
  input logic [LVL_W:0]   depth
);
  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !irq |-> (irq_id == '0 && irq_lvl == '0));

  p_below_thr_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq |-> ({1'b0, irq_lvl} < thr));

  p_push_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ack && irq && !eoi && depth < (LVL_W+1)'(N_LVL)) |=>
      depth == (LVL_W+1)'($past(depth) + 1'b1));

  p_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (eoi && !ack && depth != '0) |=> depth == (LVL_W+1)'($past(depth) - 1'b1));

  p_empty_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (eoi && depth == '0 && !(ack && irq)) |=> depth == '0);

  p_noack_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!(ack && irq) && !eoi) |=> $stable(depth));

  p_depth_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    depth <= (LVL_W+1)'(N_LVL));
endmodule

bind pic_vic pic_vic_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n_sync),
  .irq     (irq_o),
  .irq_id  (irq_id_o),
  .irq_lvl (irq_lvl_o),
  .ack     (ack_i),
  .eoi     (eoi_i),
  .thr     (thr),
  .depth   (depth)
);

// File: tb/pic_vic_tb.sv
module pic_vic_tb;
  localparam int N_SRC = 32;
  localparam int LVL_W = 3;
  localparam int ID_W  = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N_SRC-1:0] src;
  logic             cfg_we, clr_we, ack, eoi, cfg_en;
  logic [ID_W-1:0]  cfg_src, clr_src, irq_id;
  logic [1:0]       cfg_trig;
  logic [LVL_W-1:0] cfg_lvl, irq_lvl;
  logic             irq;

  always #4 clk = ~clk;

  pic_vic #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .cfg_we_i(cfg_we), .cfg_src_i(cfg_src), .cfg_trig_i(cfg_trig),
    .cfg_lvl_i(cfg_lvl), .cfg_en_i(cfg_en),
    .clr_we_i(clr_we), .clr_src_i(clr_src),
    .ack_i(ack), .eoi_i(eoi),
    .irq_o(irq), .irq_id_o(irq_id), .irq_lvl_o(irq_lvl)
  );

  typedef struct packed {
    logic             e_irq;
    logic [ID_W-1:0]  e_id;
    logic [LVL_W-1:0] e_lvl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  event  smp_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // Monitor: pops expectations and compares against the live outputs.
  initial begin
    forever begin
      @(smp_ev);
      while (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (irq !== e.e_irq || irq_id !== e.e_id || irq_lvl !== e.e_lvl) begin
          n_fail++;
          $display("FAIL %s: got irq=%0b id=%0d lvl=%0d, expected irq=%0b id=%0d lvl=%0d",
                   t, irq, irq_id, irq_lvl, e.e_irq, e.e_id, e.e_lvl);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(bit i, int id, int lvl, string tag);
    exp_q.push_back('{i, ID_W'(id), LVL_W'(lvl)});
    tag_q.push_back(tag);
    -> smp_ev;
    #1;
  endtask

  task automatic cfg(int s, logic [1:0] t, int l, bit en);
    cfg_we = 1'b1; cfg_src = ID_W'(s); cfg_trig = t; cfg_lvl = LVL_W'(l); cfg_en = en;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic clr(int s);
    clr_we = 1'b1; clr_src = ID_W'(s);
    step(1);
    clr_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1; step(1); eoi = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; cfg_we = 0; clr_we = 0; ack = 0; eoi = 0;
    cfg_src = '0; cfg_trig = '0; cfg_lvl = '0; cfg_en = 0; clr_src = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    expect_out(0, 0, 0, "R1 reset");
    src[4] = 1'b1; step(1);
    expect_out(0, 0, 0, "R1 disabled after reset");
    src[4] = 1'b0;

    // R2 high level, R9 level latency
    cfg(5, 2'b01, 3, 1);
    src[5] = 1'b1; step(1);
    expect_out(1, 5, 3, "R9 level one edge");
    src[5] = 1'b0; step(1);
    expect_out(0, 0, 0, "R2 high level released");

    // R2 low level
    cfg(9, 2'b00, 2, 1);
    expect_out(1, 9, 2, "R2 low level active");
    src[9] = 1'b1; step(1);
    expect_out(0, 0, 0, "R2 low level inactive");

    // R3 rising edge with R9 latency
    cfg(12, 2'b11, 4, 1);
    src[12] = 1'b1; step(1);
    expect_out(0, 0, 0, "R9 edge not yet");
    step(1);
    expect_out(1, 12, 4, "R9 edge after two");
    src[12] = 1'b0; step(2);
    expect_out(1, 12, 4, "R3 edge held");
    clr(12);
    expect_out(0, 0, 0, "R3 clear write");

    // R2 falling edge ignores rising
    cfg(20, 2'b10, 4, 1);
    src[20] = 1'b1; step(2);
    expect_out(0, 0, 0, "R2 falling ignores rise");
    src[20] = 1'b0; step(2);
    expect_out(1, 20, 4, "R2 falling latched");
    clr(20);
    expect_out(0, 0, 0, "R3 clear falling");

    // R4 disabled source still latches
    cfg(7, 2'b11, 1, 0);
    src[7] = 1'b1; step(2); src[7] = 1'b0; step(2);
    expect_out(0, 0, 0, "R4 masked");
    cfg(7, 2'b11, 1, 1);
    expect_out(1, 7, 1, "R4 pending on enable");

    // R5 level order
    src[5] = 1'b1; step(1);
    expect_out(1, 7, 1, "R5 lvl1 beats lvl3");
    clr(7);
    expect_out(1, 5, 3, "R5 lvl3 remains");

    // R6 tie on source number
    cfg(30, 2'b01, 3, 1);
    src[30] = 1'b1; step(1);
    expect_out(1, 5, 3, "R6 5 beats 30");
    cfg(3, 2'b01, 3, 1);
    src[3] = 1'b1; step(1);
    expect_out(1, 3, 3, "R6 3 beats 5");

    // R7 nesting
    pulse_ack();
    expect_out(0, 0, 0, "R7 equal level held off");
    src[12] = 1'b1; step(1); src[12] = 1'b0; step(2);
    expect_out(0, 0, 0, "R7 lower level held off");
    cfg(25, 2'b01, 2, 1);
    src[25] = 1'b1; step(1);
    expect_out(1, 25, 2, "R7 preempt");
    pulse_ack();
    expect_out(0, 0, 0, "R7 second push");

    // R8 unwind
    pulse_eoi();
    expect_out(1, 25, 2, "R8 pop to lvl3");
    pulse_eoi();
    expect_out(1, 25, 2, "R8 pop to empty");
    pulse_eoi();
    expect_out(1, 25, 2, "R8 empty pop ignored");
    src[25] = 0; src[3] = 0; src[5] = 0; src[30] = 0; step(1);
    expect_out(1, 12, 4, "R3 pending survives");
    pulse_ack();
    expect_out(0, 0, 0, "R7 after ack lvl4");
    pulse_eoi();
    expect_out(0, 0, 0, "R3 ack clears pending");
    pulse_ack();
    src[5] = 1'b1; step(1);
    expect_out(1, 5, 3, "R8 idle ack no push");
    src[5] = 1'b0; step(1);

    // R10 full depth
    for (int k = 0; k < 8; k++) cfg(24 + k, 2'b01, 7 - k, 1);
    for (int k = 0; k < 8; k++) begin
      src[24 + k] = 1'b1; step(1);
      expect_out(1, 24 + k, 7 - k, "R10 climb");
      pulse_ack();
    end
    expect_out(0, 0, 0, "R10 stack full");
    pulse_eoi();
    expect_out(1, 31, 0, "R10 first pop");
    for (int k = 0; k < 8; k++) pulse_eoi();
    src[31] = 1'b0; step(1);
    expect_out(1, 30, 1, "R10 stack empty");
    for (int k = 24; k < 31; k++) src[k] = 1'b0;
    step(1);
    expect_out(0, 0, 0, "R10 all quiet");

    step(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule